// File: doc/BRIEF.md
# Sound Unit Master Control, Step Timebase and Output Mixer

This block is the central controller of a four-channel sound unit. It holds the master volume register, the per-channel left/right routing register and the power register. It decides which byte writes on the sound register port reach the channel generators, based on the power state and a hardware-revision input. The channel generators themselves sit outside this block. It receives one write strobe and the written byte, already filtered, per cycle.

While powered, a 12-bit cycle counter and a 3-bit phase counter form the step timebase. The block pulses a length clock, a sweep clock and an envelope clock toward the channels on the phases each one uses. The four 4-bit channel samples are summed per side according to routing. Each sum is scaled by the side's volume and passed through a fixed-point DC-blocking high-pass filter. The result appears on signed 16-bit left and right outputs.

Top module: `snd_master`

## Requirements
- R1: A read of address 0x24 returns the volume register as {left enable (bit 7), left volume (bits 6:4), right enable (bit 3), right volume (bits 2:0)}, exactly as last written while powered.
- R2: Address 0x25 is the routing register: bit n sends channel n (n = 0..3, sample bits 4n+3:4n of `smp_i`) to the right output, and bit n+4 sends it to the left output. It reads back as written.
- R3: Address 0x26 bit 7 is the power bit, and a read returns {power, 7'h7F}. After reset the unit is unpowered and both the volume and routing registers read 0.
- R4: A read of any address other than 0x24, 0x25 and 0x26 returns 0xFF.
- R5: While unpowered, a write to 0x24 or 0x25 leaves the register unchanged, and no channel write strobe is raised except as allowed by R6.
- R6: While unpowered with `legacy_i` high, writes to the channel length addresses 0x11, 0x16, 0x1B and 0x20 are forwarded. For 0x11 and 0x16 the forwarded byte is the written byte AND 0x3F. With `legacy_i` low, none of them is forwarded.
- R7: While powered, writes to 0x10..0x23 and 0x30..0x3F are forwarded unmodified on `chan_we_o`/`chan_wdata_o` in the same cycle. Writes to any other address are not forwarded.
- R8: Writing 0x26 with bit 7 clear zeroes the volume and routing registers at the same edge.
- R9: While unpowered, the cycle and phase counters are held at 0. While powered, the cycle counter increments every clock (mod 4096) and the phase increments (mod 8) on each clock that leaves cycle 0. `len_clk_o` is high in the cycles where cycle = 0 and the phase is even, so it is high in the first cycle after power comes on.
- R10: `sweep_clk_o` is high when cycle = 0 and phase is 2 or 6. `env_clk_o` is high when cycle = 0 and phase is 7. All three step clocks are low while unpowered.
- R11: The mix of each side is (sum of the samples routed to it) × (side volume + 1) × 64. Both mixes are 0 while unpowered.
- R12: Each side keeps a 64-bit signed bias, reset to 0. Every clock, the bias is updated as bias += (((mix<<16) − (bias>>>16)) × 57593)>>>16. The output register then takes mix − (new bias>>>32), saturated to signed 16 bits. The output therefore lags the mix by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Low byte of the register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| legacy_i | input | 1 | Older hardware revision select |
| chan_we_o | output | 1 | Write strobe forwarded to the channel generators |
| chan_wdata_o | output | 8 | Forwarded (possibly masked) write data |
| smp_i | input | 16 | Four 4-bit unsigned channel samples, channel n at bits 4n+3:4n |
| len_clk_o | output | 1 | Length counter step pulse |
| sweep_clk_o | output | 1 | Frequency sweep step pulse |
| env_clk_o | output | 1 | Volume envelope step pulse |
| out_l_o | output | 16 | Filtered left output, signed |
| out_r_o | output | 16 | Filtered right output, signed |

## Verification
The routing and volume registers are tried with asymmetric settings, so that crossing the left and right fields or shifting the volume field shows up on the outputs. The samples are changed every few thousand cycles, so the filter is seen both charging toward a steady DC level and swinging negative when the input drops. Write gating is driven with the unpowered legacy, unpowered non-legacy and powered states. It covers the masked and unmasked length addresses and addresses just outside the forwarded ranges, which separates the masking rule from the range rule. The timebase runs for more than a full eight-phase round, so the phase decoding and the reset of the counters on power-on are both observed.

// File: rtl/snd_pkg.sv
package snd_pkg;
  localparam logic [7:0] A_VOL   = 8'h24;
  localparam logic [7:0] A_ROUTE = 8'h25;
  localparam logic [7:0] A_PWR   = 8'h26;
  localparam logic [7:0] A_LEN1  = 8'h11;
  localparam logic [7:0] A_LEN2  = 8'h16;
  localparam logic [7:0] A_LEN3  = 8'h1B;
  localparam logic [7:0] A_LEN4  = 8'h20;
  localparam logic [7:0] A_CH_LO = 8'h10;
  localparam logic [7:0] A_CH_HI = 8'h23;
  localparam logic [7:0] A_WV_LO = 8'h30;
  localparam logic [7:0] A_WV_HI = 8'h3F;
  localparam logic [7:0] LEN_MASK = 8'h3F;

  typedef struct packed {
    logic       l_en;
    logic [2:0] l_vol;
    logic       r_en;
    logic [2:0] r_vol;
  } vol_t;
endpackage

// File: rtl/snd_regs.sv
module snd_regs
  import snd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       legacy_i,
  output logic [7:0] rdata_o,
  output logic       chan_we_o,
  output logic [7:0] chan_wdata_o,
  output logic       pwr_o,
  output logic [2:0] l_vol_o,
  output logic [2:0] r_vol_o,
  output logic [7:0] route_o
);
  vol_t       vol_q;
  logic [7:0] route_q;
  logic       pwr_q;
  logic       in_chan, len_hit, duty_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q   <= '0;
      route_q <= '0;
      pwr_q   <= 1'b0;
    end else if (we_i) begin
      if (addr_i == A_PWR) begin
        pwr_q <= wdata_i[7];
        if (!wdata_i[7]) begin
          vol_q   <= '0;
          route_q <= '0;
        end
      end else if (pwr_q && addr_i == A_VOL) begin
        vol_q <= vol_t'(wdata_i);
      end else if (pwr_q && addr_i == A_ROUTE) begin
        route_q <= wdata_i;
      end
    end
  end

  always_comb begin
    in_chan  = (addr_i >= A_CH_LO && addr_i <= A_CH_HI) ||
               (addr_i >= A_WV_LO && addr_i <= A_WV_HI);
    duty_hit = (addr_i == A_LEN1) || (addr_i == A_LEN2);
    len_hit  = duty_hit || (addr_i == A_LEN3) || (addr_i == A_LEN4);
  end

  assign chan_we_o    = we_i && in_chan && (pwr_q || (legacy_i && len_hit));
  assign chan_wdata_o = (!pwr_q && duty_hit) ? (wdata_i & LEN_MASK) : wdata_i;

  always_comb begin
    unique case (addr_i)
      A_VOL:   rdata_o = vol_q;
      A_ROUTE: rdata_o = route_q;
      A_PWR:   rdata_o = {pwr_q, 7'h7F};
      default: rdata_o = 8'hFF;
    endcase
  end

  assign pwr_o   = pwr_q;
  assign l_vol_o = vol_q.l_vol;
  assign r_vol_o = vol_q.r_vol;
  assign route_o = route_q;

  // R5: unpowered volume write has no effect
  a_r5_off_vol_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_q && we_i && addr_i == A_VOL) |=> $stable(vol_q));
  // R6: forwarding while unpowered needs the legacy revision
  a_r6_off_fwd_legacy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_we_o && !pwr_q) |-> legacy_i);
  // R8: losing power leaves cleared registers
  a_r8_clear_on_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_q) |-> (vol_q == '0 && route_q == '0));
endmodule

// File: rtl/snd_frame_seq.sv
module snd_frame_seq #(
  parameter int CYC_W = 12,
  parameter int PH_W  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic len_clk_o,
  output logic sweep_clk_o,
  output logic env_clk_o
);
  logic [CYC_W-1:0] cyc_q;
  logic [PH_W-1:0]  ph_q;
  logic             step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      ph_q  <= '0;
    end else if (!run_i) begin
      cyc_q <= '0;
      ph_q  <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (cyc_q == '0) ph_q <= ph_q + 1'b1;
    end
  end

  assign step        = run_i && (cyc_q == '0);
  assign len_clk_o   = step && !ph_q[0];
  assign sweep_clk_o = step && (ph_q[1:0] == 2'b10);
  assign env_clk_o   = step && (ph_q == '1);

  // R10: sweep only on length phases, envelope never on one
  a_r10_sweep_on_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_clk_o |-> len_clk_o);
  a_r10_env_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    env_clk_o |-> !len_clk_o);
  // R9: a length pulse lasts one cycle
  a_r9_len_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_clk_o |=> !len_clk_o);
endmodule

// File: rtl/snd_mixer.sv
module snd_mixer #(
  parameter int N_CH    = 4,
  parameter int SMP_W   = 4,
  parameter int VOL_W   = 3,
  parameter int OUT_W   = 16,
  parameter int GAIN_SH = 6
) (
  input  logic [N_CH*SMP_W-1:0] smp_i,
  input  logic [N_CH-1:0]       sel_i,
  input  logic [VOL_W-1:0]      vol_i,
  input  logic                  en_i,
  output logic signed [OUT_W-1:0] mix_o
);
  localparam int SUM_W = SMP_W + $clog2(N_CH + 1);
  localparam int MIX_W = SUM_W + VOL_W + 1;

  logic [SUM_W-1:0] sum;
  logic [MIX_W-1:0] prod;
  logic [OUT_W-1:0] scaled;

  always_comb begin
    sum = '0;
    for (int n = 0; n < N_CH; n++) begin
      if (sel_i[n]) sum = sum + SUM_W'(smp_i[n*SMP_W +: SMP_W]);
    end
    prod   = MIX_W'(sum) * (MIX_W'(vol_i) + MIX_W'(1));
    scaled = OUT_W'(prod) << GAIN_SH;
  end

  assign mix_o = en_i ? signed'(scaled) : '0;
endmodule

// File: rtl/snd_dc_block.sv
module snd_dc_block #(
  parameter int W    = 16,
  parameter int COEF = 57593,
  parameter int CSH  = 16,
  parameter int BSH  = 16,
  parameter int OSH  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] x_i,
  output logic signed [W-1:0] y_o
);
  localparam logic signed [63:0] COEF_S = 64'(COEF);
  localparam logic signed [63:0] MAX_V  = (64'sd1 <<< (W-1)) - 64'sd1;
  localparam logic signed [63:0] MIN_V  = -(64'sd1 <<< (W-1));

  logic signed [63:0] bias_q, bias_n, xs, diff, prod, yd;
  logic signed [W-1:0] y_n;

  always_comb begin
    xs     = {{(64-W){x_i[W-1]}}, x_i};
    diff   = (xs <<< CSH) - (bias_q >>> BSH);
    prod   = diff * COEF_S;
    bias_n = bias_q + (prod >>> CSH);
    yd     = xs - (bias_n >>> OSH);
    if (yd > MAX_V)      y_n = MAX_V[W-1:0];
    else if (yd < MIN_V) y_n = MIN_V[W-1:0];
    else                 y_n = yd[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bias_q <= '0;
      y_o    <= '0;
    end else begin
      bias_q <= bias_n;
      y_o    <= y_n;
    end
  end

  // R12: silent input on an empty bias stays silent
  a_r12_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i == '0 && bias_q == '0) |=> (bias_q == '0 && y_o == '0));
endmodule

// File: rtl/snd_master.sv
module snd_master #(
  parameter int N_CH  = 4,
  parameter int SMP_W = 4,
  parameter int OUT_W = 16,
  parameter int CYC_W = 12,
  parameter int PH_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [7:0]              addr_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  input  logic                    legacy_i,
  output logic                    chan_we_o,
  output logic [7:0]              chan_wdata_o,
  input  logic [N_CH*SMP_W-1:0]   smp_i,
  output logic                    len_clk_o,
  output logic                    sweep_clk_o,
  output logic                    env_clk_o,
  output logic signed [OUT_W-1:0] out_l_o,
  output logic signed [OUT_W-1:0] out_r_o
);
  localparam int N_SIDE = 2;  // 0 = right, 1 = left

  logic                    pwr;
  logic [2:0]              l_vol, r_vol;
  logic [7:0]              route;
  logic [2:0]              side_vol [N_SIDE];
  logic signed [OUT_W-1:0] side_mix [N_SIDE];
  logic signed [OUT_W-1:0] side_out [N_SIDE];

  snd_regs u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .legacy_i,
    .rdata_o, .chan_we_o, .chan_wdata_o,
    .pwr_o(pwr), .l_vol_o(l_vol), .r_vol_o(r_vol), .route_o(route)
  );

  snd_frame_seq #(.CYC_W(CYC_W), .PH_W(PH_W)) u_seq (
    .clk_i, .rst_ni, .run_i(pwr),
    .len_clk_o, .sweep_clk_o, .env_clk_o
  );

  assign side_vol[0] = r_vol;
  assign side_vol[1] = l_vol;

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    snd_mixer #(.N_CH(N_CH), .SMP_W(SMP_W), .VOL_W(3), .OUT_W(OUT_W)) u_mix (
      .smp_i, .sel_i(route[s*N_CH +: N_CH]), .vol_i(side_vol[s]),
      .en_i(pwr), .mix_o(side_mix[s])
    );
    snd_dc_block #(.W(OUT_W)) u_dc (
      .clk_i, .rst_ni, .x_i(side_mix[s]), .y_o(side_out[s])
    );
  end

  assign out_r_o = side_out[0];
  assign out_l_o = side_out[1];

  // R11: nothing reaches the filters while unpowered
  a_r11_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr |-> (side_mix[0] == '0 && side_mix[1] == '0));
  // R10: no step pulses while unpowered
  a_r10_off_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr |-> !(len_clk_o || sweep_clk_o || env_clk_o));
endmodule

// File: tb/snd_master_tb_top.sv
module snd_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [7:0]  wdata_i = 8'h00;
  logic        legacy_i = 1'b0;
  logic [15:0] smp_i = 16'h0;
  logic [7:0]  rdata_o, chan_wdata_o;
  logic        chan_we_o, len_clk_o, sweep_clk_o, env_clk_o;
  logic signed [15:0] out_l_o, out_r_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  snd_master dut_i (
    .clk_i(clk), .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .legacy_i,
    .chan_we_o, .chan_wdata_o, .smp_i, .len_clk_o, .sweep_clk_o, .env_clk_o,
    .out_l_o, .out_r_o
  );

  // reference model state
  int      m_vol, m_route, m_pwr, m_cyc, m_ph;
  longint  m_bias_l, m_bias_r;
  int      m_out_l, m_out_r;

  task automatic check(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mix_of(int sel, int vol, int pwr, logic [15:0] s);
    int sum = 0;
    if (pwr == 0) return 0;
    for (int n = 0; n < 4; n++)
      if (((sel >> n) & 1) != 0) sum += int'(s[n*4 +: 4]);
    return sum * (vol + 1) * 64;
  endfunction

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic filt(int mix, ref longint bias, ref int y);
    longint x = longint'(mix);
    bias = bias + ((((x <<< 16) - (bias >>> 16)) * 64'sd57593) >>> 16);
    y = sat16(x - (bias >>> 32));
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_vol = 0; m_route = 0; m_pwr = 0; m_cyc = 0; m_ph = 0;
      m_bias_l = 0; m_bias_r = 0; m_out_l = 0; m_out_r = 0;
    end else begin
      filt(mix_of(m_route >> 4, (m_vol >> 4) & 7, m_pwr, smp_i), m_bias_l, m_out_l);
      filt(mix_of(m_route & 15, m_vol & 7, m_pwr, smp_i), m_bias_r, m_out_r);
      if (m_pwr != 0) begin
        if (m_cyc == 0) m_ph = (m_ph + 1) % 8;
        m_cyc = (m_cyc + 1) % 4096;
      end else begin
        m_cyc = 0; m_ph = 0;
      end
      if (we_i) begin
        if (addr_i == 8'h26) begin
          m_pwr = int'(wdata_i[7]);
          if (m_pwr == 0) begin m_vol = 0; m_route = 0; end
        end else if (m_pwr != 0 && addr_i == 8'h24) m_vol = int'(wdata_i);
        else if (m_pwr != 0 && addr_i == 8'h25) m_route = int'(wdata_i);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int  e_rd, e_we, e_wd;
      bit  in_ch, len_a, duty_a, step;
      string tag_rd, tag_we;
      case (addr_i)
        8'h24: begin e_rd = m_vol;   tag_rd = "R1"; end
        8'h25: begin e_rd = m_route; tag_rd = "R2"; end
        8'h26: begin e_rd = (m_pwr << 7) | 8'h7F; tag_rd = "R3"; end
        default: begin e_rd = 8'hFF; tag_rd = "R4"; end
      endcase
      check(tag_rd, rdata_o, e_rd);

      in_ch  = (addr_i >= 8'h10 && addr_i <= 8'h23) || (addr_i >= 8'h30 && addr_i <= 8'h3F);
      duty_a = (addr_i == 8'h11) || (addr_i == 8'h16);
      len_a  = duty_a || (addr_i == 8'h1B) || (addr_i == 8'h20);
      e_we   = int'(we_i && in_ch && (m_pwr != 0 || (legacy_i && len_a)));
      e_wd   = (m_pwr == 0 && duty_a) ? (wdata_i & 8'h3F) : wdata_i;
      tag_we = (m_pwr != 0) ? "R7" : (legacy_i ? "R6" : "R5");
      check(tag_we, chan_we_o, e_we);
      if (e_we != 0) check(tag_we, chan_wdata_o, e_wd);

      step = (m_pwr != 0) && (m_cyc == 0);
      check("R9 len", len_clk_o, step && (m_ph % 2 == 0));
      check("R10 sweep", sweep_clk_o, step && (m_ph == 2 || m_ph == 6));
      check("R10 env", env_clk_o, step && (m_ph == 7));
      check("R11 R12 left", out_l_o, m_out_l);
      check("R11 R12 right", out_r_o, m_out_r);
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk); #1;
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(posedge clk); #1;
    addr_i = a;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    addr_i = 8'h26;
    @(negedge clk);
    check("R3 reset power", rdata_o, 8'h7F);
    check("R12 reset out", out_l_o, 0);

    // unpowered gating
    wr(8'h24, 8'h77);
    rd(8'h24);
    @(negedge clk); check("R5 vol unchanged", rdata_o, 0);
    wr(8'h11, 8'hFF);
    legacy_i = 1'b1;
    wr(8'h11, 8'hFF);
    wr(8'h16, 8'hC7);
    wr(8'h1B, 8'hC3);
    wr(8'h20, 8'h81);
    wr(8'h12, 8'h55);
    wr(8'h30, 8'h55);
    legacy_i = 1'b0;
    wr(8'h1B, 8'hC3);

    // power on
    smp_i = {4'd15, 4'd8, 4'd3, 4'd1};
    wr(8'h26, 8'h80);
    @(negedge clk); check("R9 first len pulse", len_clk_o, 1);
    wr(8'h24, 8'hB2);
    rd(8'h24);
    @(negedge clk); check("R1 vol readback", rdata_o, 8'hB2);
    wr(8'h25, 8'h5A);
    rd(8'h25);
    @(negedge clk); check("R2 route readback", rdata_o, 8'h5A);
    rd(8'h30);
    rd(8'h10);
    rd(8'h27);
    wr(8'h30, 8'h9C);
    wr(8'h23, 8'hE1);
    wr(8'h11, 8'hF0);
    wr(8'h27, 8'h11);
    wr(8'h0F, 8'h22);
    wr(8'h40, 8'h33);
    legacy_i = 1'b1;
    wr(8'h16, 8'hC7);
    legacy_i = 1'b0;
    rd(8'h26);

    // long run over more than one full phase round
    for (int k = 0; k < 12; k++) begin
      repeat (3000) @(posedge clk);
      #1;
      smp_i = (k % 3 == 2) ? 16'h0000 : 16'((k + 1) * 16'h3A5F);
      if (k == 5) begin
        we_i = 1'b1; addr_i = 8'h24; wdata_i = 8'h77;
        @(posedge clk); #1 we_i = 1'b0;
      end
      if (k == 8) begin
        we_i = 1'b1; addr_i = 8'h25; wdata_i = 8'hF3;
        @(posedge clk); #1 we_i = 1'b0;
      end
    end

    // power off clears registers
    wr(8'h26, 8'h00);
    rd(8'h24);
    @(negedge clk); check("R8 vol cleared", rdata_o, 0);
    rd(8'h25);
    @(negedge clk); check("R8 route cleared", rdata_o, 0);
    check("R10 no step off", len_clk_o | sweep_clk_o | env_clk_o, 0);
    repeat (300) @(posedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule